// File: doc/BRIEF.md
# Flash Watermark and Hide Protection Gate

This block sits in front of an on-chip flash and decides, one access at a time, whether the access may proceed. The decision depends on the page the access falls into, on whether the access is secure, and on its kind: read, write or fetch. Software defines up to two protected page spans, called watermark areas. Each span has a first page and a last page. Inside a span only secure masters may touch the flash.

Each area can also carry a hidden sub-span. It runs from the area's first page up to a configurable hide-end page. Once a runtime disable bit for that area has been set, the hidden pages refuse every access, secure or not, until the next reset.

The page size follows a bank-mode input: 4 KB pages when the flash runs as one bank, 2 KB pages in dual-bank mode. Every access gets exactly one response one clock later, carrying allow or deny. Each denial raises a one-cycle illegal-access event for an interrupt concentrator. When the security extension is switched off, the gate lets everything through.

Top module: `flash_wm_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid` and `illegal_evt` are 0, and every hide-disable bit is clear.
- R2: The page index of an access is its byte offset divided by 4096 when `bank_dual` is 0, and by 2048 when `bank_dual` is 1.
- R3: With `sec_en`=1, a non-secure access of any kind to a page p with start ≤ p ≤ end of either area is denied. A secure access there is allowed unless R5 or R10 denies it.
- R4: An area whose start page is greater than its end page covers no page.
- R5: An area's hide span is enforced only when three conditions all hold: its hide enable is 1, start ≤ hide-end ≤ end, and its hide-disable bit is set. While it is enforced, every access to pages start through hide-end is denied, whatever its security or kind.
- R6: A hide-disable bit is set by a one-cycle pulse on its `hide_lock_set` line. It takes effect for accesses presented from the next cycle on. It stays set with the pulse low and is cleared only by reset.
- R7: With `sec_en`=0, every access is allowed and no event is raised.
- R8: Each cycle with `acc_valid`=1 yields `rsp_valid`=1 in the following cycle. A cycle with `acc_valid`=0 yields `rsp_valid`=0 in the following cycle.
- R9: `illegal_evt` is 1 for exactly the response cycles in which `rsp_valid`=1 and `rsp_allow`=0.
- R10: `acc_kind` encodes read as 2'b00, write as 2'b01 and fetch as 2'b10. With `sec_en`=1, the code 2'b11 is denied on any page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_en | input | 1 | Security extension enabled |
| bank_dual | input | 1 | 1: dual-bank 2 KB pages, 0: single-bank 4 KB pages |
| cfg_wm_start | input | NUM_AREAS*PG_W | First page of each area (area i at bits i*PG_W) |
| cfg_wm_end | input | NUM_AREAS*PG_W | Last page of each area |
| cfg_hide_end | input | NUM_AREAS*PG_W | Last hidden page of each area |
| cfg_hide_en | input | NUM_AREAS | Hide span enable per area |
| hide_lock_set | input | NUM_AREAS | Pulse that sets the sticky hide-disable bit per area |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W | Byte offset into flash |
| acc_secure | input | 1 | Access is secure |
| acc_kind | input | 2 | Access kind (R10) |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | 1 allow, 0 deny |
| illegal_evt | output | 1 | One-cycle illegal-access event |

## Verification
The bench targets the page boundaries: the first and last page of each area, and the page just beyond. A gate with an off-by-one compare there would let a non-secure access into the last protected page or block the next free one. It swaps the bank mode on one fixed address. A wrong shift would put that address into or out of an area and flip the verdict. It also covers three further cases. An inverted area must protect nothing. A hide-end beyond the area's end must leave the hide span dormant, where a gate that skipped this check would wrongly block secure fetches. The hide-disable bit must survive idle cycles and be cleared only by reset, where a bit that decayed or stuck across reset would unhide or permanently hide pages.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

  // Access kind codes seen on acc_kind
  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RSVD  = 2'b11
  } acc_kind_e;

  // Page shift for each bank mode
  localparam int unsigned SHIFT_ONE_BANK = 12;
  localparam int unsigned SHIFT_TWO_BANK = 11;

  // Verdict carried through the response stage
  typedef struct packed {
    logic valid;
    logic allow;
  } verdict_t;

endpackage

// File: rtl/fwh_pager.sv
module fwh_pager #(
  parameter int ADDR_W = 19,
  parameter int PG_W   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank_dual,
  output logic [PG_W-1:0]   page
);
  import fwh_pkg::*;

  localparam int SPAN_W = ADDR_W - SHIFT_TWO_BANK;

  // Page index arithmetic kept in one function
  function automatic logic [PG_W-1:0] page_of(input logic [ADDR_W-1:0] a,
                                               input logic dual);
    logic [ADDR_W-1:0] sh;
    sh = dual ? (a >> SHIFT_TWO_BANK) : (a >> SHIFT_ONE_BANK);
    return PG_W'(sh[SPAN_W-1:0]);
  endfunction

  assign page = page_of(addr, bank_dual);

endmodule

// File: rtl/fwh_area.sv
module fwh_area #(
  parameter int PG_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PG_W-1:0] page,
  input  logic [PG_W-1:0] wm_start,
  input  logic [PG_W-1:0] wm_end,
  input  logic [PG_W-1:0] hide_end,
  input  logic            hide_en,
  input  logic            lock_set,
  output logic            wm_hit,
  output logic            hide_hit,
  output logic            hide_armed,
  output logic            lock_q
);

  // Inclusive span test; an inverted span holds nothing
  function automatic logic in_span(input logic [PG_W-1:0] p,
                                   input logic [PG_W-1:0] lo,
                                   input logic [PG_W-1:0] hi);
    return (lo <= hi) && (p >= lo) && (p <= hi);
  endfunction

  // Hide span is well formed only when nested inside the area
  function automatic logic hide_ok(input logic en,
                                   input logic [PG_W-1:0] lo,
                                   input logic [PG_W-1:0] hmark,
                                   input logic [PG_W-1:0] hi);
    return en && (lo <= hmark) && (hmark <= hi);
  endfunction

  logic hide_shape_ok;

  // Sticky disable bit, cleared only by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_set) begin
      lock_q <= 1'b1;
    end
  end

  always_comb begin
    hide_shape_ok = hide_ok(hide_en, wm_start, hide_end, wm_end);
    hide_armed    = hide_shape_ok && lock_q;
    wm_hit        = in_span(page, wm_start, wm_end);
    hide_hit      = hide_armed && in_span(page, wm_start, hide_end);
  end

endmodule

// File: rtl/fwh_resolve.sv
module fwh_resolve #(
  parameter int NUM_AREAS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sec_en,
  input  logic                 acc_valid,
  input  logic                 acc_secure,
  input  logic [1:0]           acc_kind,
  input  logic [NUM_AREAS-1:0] wm_hits,
  input  logic [NUM_AREAS-1:0] hide_hits,
  output logic                 deny_now,
  output logic                 rsp_valid,
  output logic                 rsp_allow,
  output logic                 illegal_evt
);
  import fwh_pkg::*;

  verdict_t nxt, cur;

  function automatic logic must_deny(input logic en,
                                     input logic secure,
                                     input logic [1:0] kind,
                                     input logic any_wm,
                                     input logic any_hide);
    if (!en) return 1'b0;
    if (acc_kind_e'(kind) == KIND_RSVD) return 1'b1;
    if (any_hide) return 1'b1;
    return !secure && any_wm;
  endfunction

  always_comb begin
    deny_now  = must_deny(sec_en, acc_secure, acc_kind, |wm_hits, |hide_hits);
    nxt.valid = acc_valid;
    nxt.allow = acc_valid && !deny_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur         <= '0;
      illegal_evt <= 1'b0;
    end else begin
      cur         <= nxt;
      illegal_evt <= acc_valid && deny_now;
    end
  end

  assign rsp_valid = cur.valid;
  assign rsp_allow = cur.allow;

endmodule

// File: rtl/flash_wm_gate.sv
module flash_wm_gate #(
  parameter int ADDR_W    = 19,
  parameter int PG_W      = 8,
  parameter int NUM_AREAS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sec_en,
  input  logic                      bank_dual,
  input  logic [NUM_AREAS*PG_W-1:0] cfg_wm_start,
  input  logic [NUM_AREAS*PG_W-1:0] cfg_wm_end,
  input  logic [NUM_AREAS*PG_W-1:0] cfg_hide_end,
  input  logic [NUM_AREAS-1:0]      cfg_hide_en,
  input  logic [NUM_AREAS-1:0]      hide_lock_set,
  input  logic                      acc_valid,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic                      acc_secure,
  input  logic [1:0]                acc_kind,
  output logic                      rsp_valid,
  output logic                      rsp_allow,
  output logic                      illegal_evt
);

  logic [PG_W-1:0]      page;
  logic [NUM_AREAS-1:0] wm_hits;
  logic [NUM_AREAS-1:0] hide_hits;
  logic [NUM_AREAS-1:0] hide_armed;
  logic [NUM_AREAS-1:0] lock_q;
  logic                 deny_now;

  fwh_pager #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_pager (
    .addr      (acc_addr),
    .bank_dual (bank_dual),
    .page      (page)
  );

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
    fwh_area #(.PG_W(PG_W)) u_area (
      .clk        (clk),
      .rst_n      (rst_n),
      .page       (page),
      .wm_start   (cfg_wm_start[i*PG_W +: PG_W]),
      .wm_end     (cfg_wm_end[i*PG_W +: PG_W]),
      .hide_end   (cfg_hide_end[i*PG_W +: PG_W]),
      .hide_en    (cfg_hide_en[i]),
      .lock_set   (hide_lock_set[i]),
      .wm_hit     (wm_hits[i]),
      .hide_hit   (hide_hits[i]),
      .hide_armed (hide_armed[i]),
      .lock_q     (lock_q[i])
    );
  end

  fwh_resolve #(.NUM_AREAS(NUM_AREAS)) u_resolve (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_en      (sec_en),
    .acc_valid   (acc_valid),
    .acc_secure  (acc_secure),
    .acc_kind    (acc_kind),
    .wm_hits     (wm_hits),
    .hide_hits   (hide_hits),
    .deny_now    (deny_now),
    .rsp_valid   (rsp_valid),
    .rsp_allow   (rsp_allow),
    .illegal_evt (illegal_evt)
  );

endmodule

// File: rtl/fwh_chk.sv
module fwh_chk #(
  parameter int NUM_AREAS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sec_en,
  input logic                 acc_valid,
  input logic                 acc_secure,
  input logic [NUM_AREAS-1:0] wm_hits,
  input logic [NUM_AREAS-1:0] hide_hits,
  input logic [NUM_AREAS-1:0] hide_armed,
  input logic [NUM_AREAS-1:0] lock_q,
  input logic [NUM_AREAS-1:0] hide_lock_set,
  input logic                 rsp_valid,
  input logic                 rsp_allow,
  input logic                 illegal_evt
);

  // R8
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  // R8
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);

  // R9
  evt_marks_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_evt |-> (rsp_valid && !rsp_allow));

  // R9
  deny_raises_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_allow) |-> illegal_evt);

  // R5
  hide_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && sec_en && (|hide_hits)) |=> !rsp_allow);

  // R3
  ns_wm_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && sec_en && !acc_secure && (|wm_hits)) |=> !rsp_allow);

  // R7
  open_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !sec_en) |=> (rsp_allow && !illegal_evt));

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_lk
    // R6
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[i] |=> lock_q[i]);

    // R6
    lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q[i]) |-> $past(hide_lock_set[i]));

    // R5
    armed_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hide_armed[i] |-> lock_q[i]);
  end

endmodule

bind flash_wm_gate fwh_chk #(.NUM_AREAS(NUM_AREAS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sec_en        (sec_en),
  .acc_valid     (acc_valid),
  .acc_secure    (acc_secure),
  .wm_hits       (wm_hits),
  .hide_hits     (hide_hits),
  .hide_armed    (hide_armed),
  .lock_q        (lock_q),
  .hide_lock_set (hide_lock_set),
  .rsp_valid     (rsp_valid),
  .rsp_allow     (rsp_allow),
  .illegal_evt   (illegal_evt)
);

// File: tb/sim_flash_wm_gate.sv
`timescale 1ns/1ps
module sim_flash_wm_gate;
  localparam int ADDR_W = 19;
  localparam int PG_W   = 8;
  localparam int NA     = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_en = 1'b1;
  logic bank_dual = 1'b0;
  logic [NA*PG_W-1:0] cfg_wm_start = '0;
  logic [NA*PG_W-1:0] cfg_wm_end = '0;
  logic [NA*PG_W-1:0] cfg_hide_end = '0;
  logic [NA-1:0] cfg_hide_en = '0;
  logic [NA-1:0] hide_lock_set = '0;
  logic acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic acc_secure = 1'b0;
  logic [1:0] acc_kind = 2'b00;
  logic rsp_valid, rsp_allow, illegal_evt;

  int checks = 0;
  int errors = 0;
  bit model_lock [NA];
  bit done = 0;

  always #2 clk = ~clk;

  flash_wm_gate #(.ADDR_W(ADDR_W), .PG_W(PG_W), .NUM_AREAS(NA)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .bank_dual(bank_dual),
    .cfg_wm_start(cfg_wm_start), .cfg_wm_end(cfg_wm_end),
    .cfg_hide_end(cfg_hide_end), .cfg_hide_en(cfg_hide_en),
    .hide_lock_set(hide_lock_set), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_secure(acc_secure), .acc_kind(acc_kind),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .illegal_evt(illegal_evt)
  );

  // Reference: page by division, per requirement
  function automatic int ref_page(input int addr, input bit dual);
    int p;
    p = dual ? addr / 2048 : addr / 4096;
    return p % 256;
  endfunction

  function automatic bit ref_allow(input int addr, input bit sec, input int kind);
    int p;
    int s, e, h;
    if (!sec_en) return 1;
    if (kind == 3) return 0;
    p = ref_page(addr, bank_dual);
    for (int i = 0; i < NA; i++) begin
      s = cfg_wm_start[i*PG_W +: PG_W];
      e = cfg_wm_end[i*PG_W +: PG_W];
      h = cfg_hide_end[i*PG_W +: PG_W];
      if (cfg_hide_en[i] && model_lock[i] && s <= h && h <= e && p >= s && p <= h)
        return 0;
      if (!sec && s <= e && p >= s && p <= e) return 0;
    end
    return 1;
  endfunction

  task automatic set_area(input int i, input int s, input int e, input int h, input bit en);
    cfg_wm_start[i*PG_W +: PG_W] = PG_W'(s);
    cfg_wm_end[i*PG_W +: PG_W]   = PG_W'(e);
    cfg_hide_end[i*PG_W +: PG_W] = PG_W'(h);
    cfg_hide_en[i] = en;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one access at a negedge, sample the response at the next negedge
  task automatic access(input string req, input int addr, input bit sec, input int kind);
    bit exp;
    @(negedge clk);
    acc_valid = 1'b1;
    acc_addr = ADDR_W'(addr);
    acc_secure = sec;
    acc_kind = 2'(kind);
    exp = ref_allow(addr, sec, kind);
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, "rsp_valid", int'(rsp_valid), 1);
    check(req, "rsp_allow", int'(rsp_allow), int'(exp));
    check("R9", "illegal_evt", int'(illegal_evt), int'(!exp));
  endtask

  task automatic pulse_lock(input int i);
    @(negedge clk);
    hide_lock_set[i] = 1'b1;
    @(negedge clk);
    hide_lock_set[i] = 1'b0;
    model_lock[i] = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < NA; i++) model_lock[i] = 0;
    @(negedge clk);
    check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    check("R1", "illegal_evt in reset", int'(illegal_evt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7177));
    for (int i = 0; i < NA; i++) model_lock[i] = 0;
    set_area(0, 2, 5, 3, 1);
    set_area(1, 30, 20, 25, 1);
    repeat (2) @(negedge clk);
    check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    check("R1", "illegal_evt in reset", int'(illegal_evt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "idle rsp_valid", int'(rsp_valid), 0);

    // R3: boundaries of area 0 (pages 2..5, 4 KB pages)
    access("R3", 4*4096 + 5, 0, 0);
    access("R3", 4*4096 + 5, 1, 0);
    access("R3", 2*4096, 0, 1);
    access("R3", 5*4096 + 4095, 0, 0);
    access("R3", 6*4096, 0, 1);
    access("R3", 1*4096 + 4095, 0, 0);
    // R4: area 1 inverted, pages 20..30 open
    access("R4", 25*4096, 0, 1);
    access("R4", 20*4096, 0, 0);
    // R5: hide not yet locked
    access("R5", 3*4096, 1, 2);
    // R6/R5: lock area 0, hide pages 2..3
    pulse_lock(0);
    access("R5", 3*4096 + 100, 1, 2);
    access("R5", 2*4096, 1, 1);
    access("R5", 4*4096, 1, 0);
    repeat (5) @(negedge clk);
    check("R8", "idle rsp_valid", int'(rsp_valid), 0);
    access("R6", 3*4096, 1, 0);
    // R2: same offset in both bank modes
    bank_dual = 1'b1;
    access("R2", 32'h2800, 0, 0);   // page 5 dual: denied
    access("R2", 32'h3000, 0, 0);   // page 6 dual: allowed
    access("R2", 32'h1000, 1, 2);   // page 2 dual: hidden
    bank_dual = 1'b0;
    access("R2", 32'h3000, 0, 0);   // page 3 single: denied
    // R5: hide end beyond area end leaves span dormant
    set_area(0, 2, 5, 7, 1);
    access("R5", 3*4096, 1, 2);
    set_area(0, 2, 5, 3, 0);
    access("R5", 3*4096, 1, 2);
    set_area(0, 2, 5, 3, 1);
    // R10: reserved kind
    access("R10", 50*4096, 1, 3);
    // R7: security off
    sec_en = 1'b0;
    access("R7", 3*4096, 1, 2);
    access("R7", 4*4096, 0, 3);
    sec_en = 1'b1;
    // R6: reset clears the lock
    do_reset();
    access("R6", 3*4096, 1, 2);

    // Random phase
    for (int blk = 0; blk < 20; blk++) begin
      for (int i = 0; i < NA; i++)
        set_area(i, $urandom % 140, $urandom % 140, $urandom % 140, 1'($urandom % 4 != 0));
      bank_dual = 1'($urandom % 2);
      sec_en = ($urandom % 8) != 0;
      if ($urandom % 3 == 0) pulse_lock($urandom % NA);
      if ($urandom % 7 == 0) do_reset();
      for (int k = 0; k < 30; k++) begin
        access("R3", $urandom % (1 << ADDR_W), 1'($urandom % 2), $urandom % 4);
        if ($urandom % 5 == 0) begin
          @(negedge clk);
          check("R8", "idle rsp_valid", int'(rsp_valid), 0);
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule